// File: doc/BRIEF.md
# Trimmed Mean Sample Filter

This block reduces a short burst of unsigned sensor readings to one filtered value. A 3-bit mode, captured when a burst opens, sets how many readings the burst holds and how they are combined. The low modes pass a single reading through or average a pair. The higher modes gather two readings beyond a power of two, throw away one largest and one smallest reading, and divide what is left by a right shift.

No sample store is kept. As each reading is accepted, a running sum, a running maximum and a running minimum are updated. On the final reading, the trimmed total is formed from the updated values and registered as the result. A sequencer upstream pulses `burst_start`, presents readings with `smp_valid`, and can use `need_count` to know how many readings the captured mode expects.

Top module: `trimmed_mean_filter`

## Requirements
- R1: Mode 0 (3'b000) takes one sample, and the result equals that sample.
- R2: Mode 1 (3'b001) takes two samples, and the result is their sum shifted right by one (truncated).
- R3: Modes 2, 3, 4 and 5 take 4, 6, 10 and 18 samples. The result is (sum − max − min) shifted right by 1, 2, 3 and 4 respectively (truncated).
- R4: When several samples share the largest or smallest value, exactly one copy of each is removed before averaging.
- R5: A burst of 18 samples, all at full scale, returns full scale, so the accumulator does not overflow.
- R6: The mode is captured on the cycle `burst_start` is high. Changes to `mode` later in the burst do not affect that burst's sample count or result.
- R7: Modes 6 and 7 behave exactly as mode 0.
- R8: `res_valid` is high for one cycle, in the cycle after the edge that accepts the burst's final sample. `res_data` keeps its value until the next result.
- R9: `need_count` gives the sample count (1, 2, 4, 6, 10, 18) of the captured mode, starting from the cycle after `burst_start`.
- R10: Samples presented while no burst is open are ignored. They produce no result and do not enter the next burst.
- R11: `burst_start` during an open burst abandons that burst with no result and opens a new one. A sample presented in the same cycle as `burst_start` is the first sample of the new burst.
- R12: After reset, `res_valid` is 0, `res_data` is 0 and `need_count` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| burst_start | input | 1 | Opens a burst and captures `mode` |
| mode | input | 3 | Filter mode, sampled with `burst_start` |
| smp_valid | input | 1 | A reading is present on `smp_data` |
| smp_data | input | DATA_W (12) | Unsigned raw reading |
| res_data | output | DATA_W (12) | Filtered result, held between results |
| res_valid | output | 1 | One-cycle strobe marking a new result |
| need_count | output | 5 | Sample count of the captured mode |

## Verification
The hardest situations to reach are the ones where bursts overlap or misbehave. These include a mode change partway through an open burst, a fresh `burst_start` that cuts off an unfinished burst, and stray readings that arrive after a burst has closed. The driver produces each of these on purpose. It holds `smp_valid` across a completed burst without `burst_start`, reopens a burst after only part of its samples, and flips `mode` on every sample after the first. Because the scoreboard queues a result only for bursts that should complete, any result from an abandoned or stray burst arrives with nothing queued and is reported. A wrong capture of the mode changes both the sample count and the expected value.

// File: rtl/tmf_pkg.sv
// Package: shared widths and mode decode for the trimmed mean filter.
// Assumes a 3-bit mode. Codes 6 and 7 decode as single-sample mode.
package tmf_pkg;
    localparam int MODE_W      = 3;
    localparam int MAX_SAMPLES = 18;
    localparam int CNT_W       = $clog2(MAX_SAMPLES + 1);
    localparam int SHIFT_W     = 3;

    typedef logic [MODE_W-1:0]  mode_t;
    typedef logic [CNT_W-1:0]   cnt_t;
    typedef logic [SHIFT_W-1:0] shift_t;

    // Samples per burst for a mode.
    function automatic cnt_t need_of(input mode_t m);
        case (m)
            3'd1:    need_of = cnt_t'(2);
            3'd2:    need_of = cnt_t'(4);
            3'd3:    need_of = cnt_t'(6);
            3'd4:    need_of = cnt_t'(10);
            3'd5:    need_of = cnt_t'(18);
            default: need_of = cnt_t'(1);
        endcase
    endfunction

    // Right shift that divides the kept total.
    function automatic shift_t shift_of(input mode_t m);
        case (m)
            3'd1, 3'd2: shift_of = shift_t'(1);
            3'd3:       shift_of = shift_t'(2);
            3'd4:       shift_of = shift_t'(3);
            3'd5:       shift_of = shift_t'(4);
            default:    shift_of = shift_t'(0);
        endcase
    endfunction

    // Whether the mode removes one maximum and one minimum.
    function automatic logic trims(input mode_t m);
        trims = (m >= 3'd2) && (m <= 3'd5);
    endfunction
endpackage

// File: rtl/tmf_burst_ctrl.sv
// Burst control: captures the mode on burst_start, counts accepted
// samples and flags the final one. Assumes burst_start has priority
// over an open burst (the open burst is abandoned).
module tmf_burst_ctrl
    import tmf_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   burst_start,
    input  mode_t  mode_in,
    input  logic   smp_valid,
    output logic   accept,
    output logic   last,
    output shift_t eff_shift,
    output logic   eff_trim,
    output cnt_t   need_q
);
    mode_t mode_q;
    logic  active_q;
    cnt_t  cnt_q;
    mode_t eff_mode;
    cnt_t  eff_need;
    cnt_t  cnt_base;
    cnt_t  cnt_inc;

    // Mode and count in force for the sample in this cycle.
    always_comb begin
        eff_mode  = burst_start ? mode_in : mode_q;
        eff_need  = need_of(eff_mode);
        eff_shift = shift_of(eff_mode);
        eff_trim  = trims(eff_mode);
        cnt_base  = burst_start ? '0 : cnt_q;
        cnt_inc   = cnt_base + cnt_t'(1);
        accept    = smp_valid && (burst_start || active_q);
        last      = accept && (cnt_inc == eff_need);
        need_q    = need_of(mode_q);
    end

    // Burst state: captured mode, open flag and sample count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= '0;
            active_q <= 1'b0;
            cnt_q    <= '0;
        end else begin
            if (burst_start)
                mode_q <= mode_in;
            if (accept) begin
                active_q <= !last;
                cnt_q    <= last ? '0 : cnt_inc;
            end else if (burst_start) begin
                active_q <= 1'b1;
                cnt_q    <= '0;
            end
        end
    end

    // R9: an open burst never holds as many samples as it needs.
    p_count_below_need_r9: assert property (@(posedge clk) disable iff (!rst_n)
        active_q |-> (cnt_q < need_of(mode_q)));

    // R6: a sample that does not close the burst leaves it open and one further.
    p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !last) |=> (active_q && cnt_q == $past(cnt_inc)));
endmodule

// File: rtl/tmf_accum.sv
// Accumulator: keeps the running sum, maximum and minimum of the open
// burst. Exposes the values updated with this cycle's sample, so the
// final result can be formed without waiting an extra cycle.
module tmf_accum #(
    parameter int DATA_W = 12,
    parameter int SUM_W  = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              accept,
    input  logic [DATA_W-1:0] data,
    output logic [SUM_W-1:0]  sum_nx,
    output logic [DATA_W-1:0] max_nx,
    output logic [DATA_W-1:0] min_nx
);
    logic [SUM_W-1:0]  sum_q;
    logic [DATA_W-1:0] max_q;
    logic [DATA_W-1:0] min_q;
    logic [SUM_W-1:0]  sum_b;
    logic [DATA_W-1:0] max_b;
    logic [DATA_W-1:0] min_b;

    // Start from cleared values on restart, then fold in an accepted sample.
    always_comb begin
        sum_b  = restart ? '0 : sum_q;
        max_b  = restart ? '0 : max_q;
        min_b  = restart ? '1 : min_q;
        sum_nx = sum_b;
        max_nx = max_b;
        min_nx = min_b;
        if (accept) begin
            sum_nx = sum_b + SUM_W'(data);
            max_nx = (data > max_b) ? data : max_b;
            min_nx = (data < min_b) ? data : min_b;
        end
    end

    // Running statistics registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q <= '0;
            max_q <= '0;
            min_q <= '1;
        end else begin
            sum_q <= sum_nx;
            max_q <= max_nx;
            min_q <= min_nx;
        end
    end

    // R5: the sum never falls below the largest sample, so it has not wrapped.
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sum_q >= SUM_W'(max_q));

    // R4: once a sample is in, the minimum does not exceed the maximum.
    p_min_le_max_r4: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (min_q <= max_q));
endmodule

// File: rtl/tmf_result.sv
// Result stage: on the final sample, removes one max and one min if the
// mode trims, shifts the total right and registers it with a strobe.
module tmf_result
    import tmf_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int SUM_W  = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic [SUM_W-1:0]  sum_nx,
    input  logic [DATA_W-1:0] max_nx,
    input  logic [DATA_W-1:0] min_nx,
    input  shift_t            shift,
    input  logic              trim,
    output logic [DATA_W-1:0] res_data,
    output logic              res_valid
);
    logic [SUM_W-1:0] kept;
    logic [SUM_W-1:0] scaled;

    // Trimmed total and its shifted average.
    always_comb begin
        kept   = trim ? (sum_nx - SUM_W'(max_nx) - SUM_W'(min_nx)) : sum_nx;
        scaled = kept >> shift;
    end

    // Result register and one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_data  <= '0;
            res_valid <= 1'b0;
        end else begin
            res_valid <= fire;
            if (fire)
                res_data <= scaled[DATA_W-1:0];
        end
    end

    // R3: a mean of kept samples lies between the burst extremes.
    p_result_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_data <= $past(max_nx) && res_data >= $past(min_nx)));

    // R8: a strobe only follows the final sample of a burst.
    p_valid_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(fire));

    // R8: the result holds while no strobe is given.
    p_result_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> $stable(res_data));
endmodule

// File: rtl/trimmed_mean_filter.sv
// Top: trimmed mean filter over a burst of unsigned samples.
// Assumes the sequencer pulses burst_start to open each burst and
// presents at most one sample per cycle.
module trimmed_mean_filter
    import tmf_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              burst_start,
    input  logic [2:0]        mode,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_data,
    output logic [DATA_W-1:0] res_data,
    output logic              res_valid,
    output logic [4:0]        need_count
);
    localparam int SUM_W = DATA_W + $clog2(MAX_SAMPLES);

    logic              accept;
    logic              last;
    shift_t            eff_shift;
    logic              eff_trim;
    cnt_t              need_q;
    logic [SUM_W-1:0]  sum_nx;
    logic [DATA_W-1:0] max_nx;
    logic [DATA_W-1:0] min_nx;

    tmf_burst_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .burst_start(burst_start),
        .mode_in    (mode),
        .smp_valid  (smp_valid),
        .accept     (accept),
        .last       (last),
        .eff_shift  (eff_shift),
        .eff_trim   (eff_trim),
        .need_q     (need_q)
    );

    tmf_accum #(.DATA_W(DATA_W), .SUM_W(SUM_W)) u_accum (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(burst_start),
        .accept (accept),
        .data   (smp_data),
        .sum_nx (sum_nx),
        .max_nx (max_nx),
        .min_nx (min_nx)
    );

    tmf_result #(.DATA_W(DATA_W), .SUM_W(SUM_W)) u_result (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (last),
        .sum_nx   (sum_nx),
        .max_nx   (max_nx),
        .min_nx   (min_nx),
        .shift    (eff_shift),
        .trim     (eff_trim),
        .res_data (res_data),
        .res_valid(res_valid)
    );

    assign need_count = need_q;

    // R10: without an open or opening burst no strobe follows.
    p_no_stray_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !burst_start && !accept) |=> !res_valid);
endmodule

// File: tb/trimmed_mean_filter_bench.sv
// Scoreboard bench: the driver queues expected results, the monitor
// compares each strobe against the queue head.
module trimmed_mean_filter_bench;
    localparam int DATA_W = 12;
    localparam int FULL   = (1 << DATA_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              burst_start = 1'b0;
    logic [2:0]        mode = 3'd0;
    logic              smp_valid = 1'b0;
    logic [DATA_W-1:0] smp_data = '0;
    logic [DATA_W-1:0] res_data;
    logic              res_valid;
    logic [4:0]        need_count;

    int checks = 0;
    int errors = 0;
    int exp_q[$];
    string tag_q[$];
    int pat[18];
    int last_exp = 0;

    trimmed_mean_filter #(.DATA_W(DATA_W)) u_trimmed_mean_filter (
        .clk        (clk),
        .rst_n      (rst_n),
        .burst_start(burst_start),
        .mode       (mode),
        .smp_valid  (smp_valid),
        .smp_data   (smp_data),
        .res_data   (res_data),
        .res_valid  (res_valid),
        .need_count (need_count)
    );

    always #10 clk = ~clk;

    function automatic int exp_need(input logic [2:0] m);
        case (m)
            3'd1: return 2;
            3'd2: return 4;
            3'd3: return 6;
            3'd4: return 10;
            3'd5: return 18;
            default: return 1;
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Driver: queue the expected mean, then present one burst.
    task automatic run_burst(input logic [2:0] m, input logic [2:0] mid_m,
                             input bit gaps, input string req);
        int n = exp_need(m);
        int sum = 0;
        int mx = 0;
        int mn = FULL;
        int kept;
        int rem;
        for (int i = 0; i < n; i++) begin
            sum += pat[i];
            if (pat[i] > mx) mx = pat[i];
            if (pat[i] < mn) mn = pat[i];
        end
        if (n >= 4) begin
            kept = sum - mx - mn;
            rem  = n - 2;
        end else begin
            kept = sum;
            rem  = n;
        end
        last_exp = kept / rem;
        exp_q.push_back(last_exp);
        tag_q.push_back(req);
        for (int i = 0; i < n; i++) begin
            if (gaps && i > 0) begin
                @(posedge clk); #1;
                burst_start = 1'b0;
                smp_valid   = 1'b0;
            end
            @(posedge clk); #1;
            burst_start = (i == 0);
            mode        = (i == 0) ? m : mid_m;
            smp_valid   = 1'b1;
            smp_data    = DATA_W'(pat[i]);
        end
        @(posedge clk); #1;
        burst_start = 1'b0;
        smp_valid   = 1'b0;
        check("R9 need_count", int'(need_count), n);
    endtask

    task automatic fill(input int seed);
        for (int i = 0; i < 18; i++)
            pat[i] = (i * 1237 + seed * 389 + 17) % (FULL + 1);
    endtask

    // Monitor: every strobe must match the queue head.
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R10/R11 unexpected result: actual %0d expected none", res_data);
            end else begin
                check(tag_q.pop_front(), int'(res_data), exp_q.pop_front());
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R12: reset values
        check("R12 res_valid", int'(res_valid), 0);
        check("R12 res_data", int'(res_data), 0);
        check("R12 need_count", int'(need_count), 1);
        rst_n = 1'b1;

        pat[0] = 1234;                       run_burst(3'd0, 3'd0, 1'b0, "R1 mode0");
        // R8: pulse lasts one cycle, value held
        @(posedge clk); #1;
        check("R8 res_valid drop", int'(res_valid), 0);
        check("R8 res_data hold", int'(res_data), 1234);

        pat[0] = 3; pat[1] = 4;              run_burst(3'd1, 3'd1, 1'b0, "R2 mode1");
        fill(1);                             run_burst(3'd1, 3'd1, 1'b1, "R2 mode1 gaps");
        pat[0:3] = '{7, 7, 7, 3};            run_burst(3'd2, 3'd2, 1'b0, "R4 tie max");
        pat[0:3] = '{9, 9, 1, 1};            run_burst(3'd2, 3'd2, 1'b0, "R4 tie both");
        pat[0:5] = '{10, 20, 30, 40, 50, 60}; run_burst(3'd3, 3'd3, 1'b0, "R3 mode3");
        for (int i = 0; i < 10; i++) pat[i] = i + 1;
        run_burst(3'd4, 3'd4, 1'b0, "R3 mode4");
        fill(2);                             run_burst(3'd5, 3'd5, 1'b1, "R3 mode5");
        fill(3);                             run_burst(3'd2, 3'd2, 1'b0, "R3 mode2");
        for (int i = 0; i < 18; i++) pat[i] = FULL;
        run_burst(3'd5, 3'd5, 1'b0, "R5 full scale");

        // R6: mode flips during the burst
        fill(4);                             run_burst(3'd2, 3'd5, 1'b0, "R6 mode held");
        fill(5);                             run_burst(3'd4, 3'd0, 1'b1, "R6 mode held long");

        // R7: reserved modes act as single sample
        pat[0] = 77;                         run_burst(3'd6, 3'd6, 1'b0, "R7 mode6");
        pat[0] = 4000;                       run_burst(3'd7, 3'd1, 1'b0, "R7 mode7");

        // R10: stray samples outside a burst
        repeat (3) begin
            @(posedge clk); #1;
            smp_valid = 1'b1;
            smp_data  = DATA_W'(999);
        end
        @(posedge clk); #1;
        smp_valid = 1'b0;
        @(posedge clk); #1;
        check("R10 res_data untouched", int'(res_data), 4000);
        pat[0] = 100; pat[1] = 201;          run_burst(3'd1, 3'd1, 1'b0, "R10 next burst clean");

        // R11: abandon an open burst after three of six samples
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); #1;
            burst_start = (i == 0);
            mode        = 3'd3;
            smp_valid   = 1'b1;
            smp_data    = DATA_W'(4000);
        end
        fill(6);                             run_burst(3'd2, 3'd2, 1'b0, "R11 restart");

        repeat (4) @(posedge clk);
        check("R8 all results seen", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule